// File: doc/BRIEF.md
# Comma-Aligned Serial Group Deserializer

This block turns a serial bit stream, one bit per clock, into 10-bit code groups. Every incoming bit lands in a shift register. On each clock the latest ten bits are compared against a 7-bit comma prefix. When alignment is enabled and the prefix is found, the group boundary snaps to that comma. The comma group is issued at once and a sync flag is raised for one group period.

Each issued group drives a one-clock pulse on one of two strobes. The strobes take turns, so each runs at half the group rate and the two are in opposite phase. A comma group always goes out on the lead strobe.

A loopback select picks the receiver's source: either the external line input or the local transmit serial stream. While looped, the external line output is parked at constant 1. The block runs entirely in the bit clock domain. Clock recovery and analog line handling sit outside it.

Top module: `sgr_deser_top`

## Requirements
- R1: Bits are assembled LSB first. The earliest-received bit of a group appears at grp_data[0] and the latest at grp_data[9]. grp_data updates in the same clock in which the group's last bit is sampled.
- R2: A comma is a 10-bit window whose seven earliest bits, in arrival order, are 0,0,1,1,1,1,1. That is grp_data[1:0]=0 and grp_data[6:2]=1, with grp_data[9:7] don't-care. A comma is recognised at any bit offset.
- R3: With align_en high, a comma group is issued in the clock its tenth bit is sampled, and the group boundary restarts there. The next group is issued exactly 10 bits later.
- R4: With align_en low, a comma has no effect. The boundary keeps its old spacing, sync_flag stays low and the strobe alternation is not disturbed.
- R5: Every issued group gives a one-clock pulse on exactly one of stb_lead and stb_lag. Between groups both strobes are low, and successive groups alternate between the two strobes.
- R6: A group issued because of an enabled comma always pulses stb_lead, and the group after it pulses stb_lag.
- R7: sync_flag rises together with an enabled comma group. It stays high for exactly 10 clocks and then falls when the next non-comma group is issued.
- R8: With loop_sel high, the receiver takes tx_ser and line_tx is held at 1. With loop_sel low, the receiver takes line_rx and line_tx follows tx_ser.
- R9: While rst_n is low, grp_data, both strobes and sync_flag are 0; reset assertion takes effect without waiting for a clock. After reset, sync_flag stays low until an enabled comma arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_rx | input | 1 | External serial input |
| tx_ser | input | 1 | Local transmit serial stream, also the loopback source |
| loop_sel | input | 1 | 1 selects loopback and parks line_tx high |
| align_en | input | 1 | 1 lets a comma realign the group boundary |
| line_tx | output | 1 | External serial output |
| grp_data | output | 10 | Last issued code group, bit 0 received first |
| stb_lead | output | 1 | Pulse for groups on the lead phase; comma groups always here |
| stb_lag | output | 1 | Pulse for groups on the opposite phase |
| sync_flag | output | 1 | High for one group period after an enabled comma |

## Verification
A corrupted bit counter shows within one group period: a group is issued early or late, or a strobe fires between boundaries. A wrong shift order shows in the first data group after a comma, as grp_data differing from the sent word. A wrong strobe phase register gives two consecutive pulses on the same strobe, or a comma group on stb_lag, visible on the first or second group after alignment. A sync flag that is gated or timed wrongly shows up within ten clocks of a comma: with alignment disabled, at the comma itself; with alignment enabled, at the next group boundary.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
  // code group width and comma prefix width
  localparam int unsigned GRP_W = 10;
  localparam int unsigned CMA_W = 7;
  // comma prefix, index 0 = earliest received bit: 0,0,1,1,1,1,1
  localparam logic [CMA_W-1:0] CMA_PAT = 7'b1111100;
  localparam int unsigned IDX_W = $clog2(GRP_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GRP_W - 1);
endpackage

// File: rtl/sgr_rst_sync.sv
module sgr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sgr_loop_sel.sv
module sgr_loop_sel (
  input  logic line_rx,
  input  logic tx_ser,
  input  logic loop_sel,
  output logic rx_bit,
  output logic line_tx
);
  always_comb begin
    if (loop_sel) begin
      rx_bit  = tx_ser;
      line_tx = 1'b1;
    end else begin
      rx_bit  = line_rx;
      line_tx = tx_ser;
    end
  end
endmodule

// File: rtl/sgr_shifter.sv
module sgr_shifter
  import sgr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  output logic [GRP_W-1:0] win_next,
  output logic             comma_hit
);
  logic [GRP_W-1:0] sh_q;
  logic [CMA_W-1:0] bit_ok;

  always_comb begin
    win_next = {rx_bit, sh_q[GRP_W-1:1]};
  end

  // per-position prefix comparison
  for (genvar i = 0; i < CMA_W; i++) begin : g_cmp
    assign bit_ok[i] = ~(win_next[i] ^ CMA_PAT[i]);
  end

  assign comma_hit = &bit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= win_next;
  end
endmodule

// File: rtl/sgr_framer.sv
module sgr_framer
  import sgr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] win_next,
  input  logic             comma_hit,
  input  logic             align_en,
  output logic             fire,
  output logic             fire_comma,
  output logic [GRP_W-1:0] grp_data,
  output logic             sync_flag
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic             sync_q, sync_d;
  logic             grp_en;

  always_comb begin
    fire_comma = align_en && comma_hit;
    fire       = fire_comma || (idx_q == IDX_LAST);
    grp_en     = fire;
    idx_d      = fire ? '0 : idx_q + 1'b1;
    grp_d      = win_next;
    sync_d     = sync_q;
    if (fire) sync_d = fire_comma;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      grp_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      sync_q <= sync_d;
      if (grp_en) grp_q <= grp_d;
    end
  end

  assign grp_data  = grp_q;
  assign sync_flag = sync_q;

  p_sync_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(align_en));

  p_sync_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> (grp_q[CMA_W-1:0] == CMA_PAT));
endmodule

// File: rtl/sgr_strobe.sv
module sgr_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic fire_comma,
  output logic stb_lead,
  output logic stb_lag
);
  logic lead_q, lead_d;
  logic lag_q, lag_d;
  logic nxt_lag_q, nxt_lag_d;

  always_comb begin
    lead_d    = 1'b0;
    lag_d     = 1'b0;
    nxt_lag_d = nxt_lag_q;
    if (fire) begin
      if (fire_comma || !nxt_lag_q) begin
        lead_d    = 1'b1;
        nxt_lag_d = 1'b1;
      end else begin
        lag_d     = 1'b1;
        nxt_lag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q    <= 1'b0;
      lag_q     <= 1'b0;
      nxt_lag_q <= 1'b0;
    end else begin
      lead_q    <= lead_d;
      lag_q     <= lag_d;
      nxt_lag_q <= nxt_lag_d;
    end
  end

  assign stb_lead = lead_q;
  assign stb_lag  = lag_q;

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_q && lag_q));
endmodule

// File: rtl/sgr_deser_top.sv
module sgr_deser_top
  import sgr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_rx,
  input  logic             tx_ser,
  input  logic             loop_sel,
  input  logic             align_en,
  output logic             line_tx,
  output logic [GRP_W-1:0] grp_data,
  output logic             stb_lead,
  output logic             stb_lag,
  output logic             sync_flag
);
  logic             rst_int_n;
  logic             rx_bit;
  logic [GRP_W-1:0] win_next;
  logic             comma_hit;
  logic             fire;
  logic             fire_comma;

  sgr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_int_n));

  sgr_loop_sel u_loop (
    .line_rx(line_rx), .tx_ser(tx_ser), .loop_sel(loop_sel),
    .rx_bit(rx_bit), .line_tx(line_tx));

  sgr_shifter u_shift (
    .clk(clk), .rst_n(rst_int_n), .rx_bit(rx_bit),
    .win_next(win_next), .comma_hit(comma_hit));

  sgr_framer u_frame (
    .clk(clk), .rst_n(rst_int_n), .win_next(win_next),
    .comma_hit(comma_hit), .align_en(align_en), .fire(fire),
    .fire_comma(fire_comma), .grp_data(grp_data), .sync_flag(sync_flag));

  sgr_strobe u_stb (
    .clk(clk), .rst_n(rst_int_n), .fire(fire), .fire_comma(fire_comma),
    .stb_lead(stb_lead), .stb_lag(stb_lag));

  p_sync_lead_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sync_flag) |-> stb_lead);

  p_sync_fall_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(sync_flag) |-> (stb_lead || stb_lag));
endmodule

// File: tb/sim_sgr_deser_top.sv
module sim_sgr_deser_top;
  logic       clk;
  logic       rst_n;
  logic       line_rx;
  logic       tx_ser;
  logic       loop_sel;
  logic       align_en;
  logic       line_tx;
  logic [9:0] grp_data;
  logic       stb_lead;
  logic       stb_lag;
  logic       sync_flag;

  int unsigned n_run;
  int unsigned n_fail;

  // bench expectation state
  logic [9:0] hist;
  int         since;
  logic       locked;
  logic       e_nxt_lag;
  logic       e_sync;

  localparam logic [9:0] COMMA = 10'b0101111100;

  sgr_deser_top u0 (
    .clk(clk), .rst_n(rst_n), .line_rx(line_rx), .tx_ser(tx_ser),
    .loop_sel(loop_sel), .align_en(align_en), .line_tx(line_tx),
    .grp_data(grp_data), .stb_lead(stb_lead), .stb_lag(stb_lag),
    .sync_flag(sync_flag));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // data word: bit0 and bit5 are 0, so no run of five ones occurs
  function automatic logic [9:0] word_of(input int i);
    logic [7:0] v;
    v = 8'(i);
    return {v[7:4], 1'b0, v[3:0], 1'b0};
  endfunction

  task automatic step(input logic b);
    logic fire, cm, txv;
    txv = ~b ^ hist[3];
    if (loop_sel) begin
      tx_ser  = b;
      line_rx = ~b;
    end else begin
      line_rx = b;
      tx_ser  = txv;
    end
    hist = {b, hist[9:1]};
    cm   = align_en && (hist[1:0] == 2'b00) && (hist[6:2] == 5'b11111);
    fire = cm || (since == 9);
    since = fire ? 0 : since + 1;
    if (cm) locked = 1'b1;
    @(posedge clk);
    #1;
    if (loop_sel) check("R8 line_tx parked", 32'(line_tx), 32'd1);
    else          check("R8 line_tx follows", 32'(line_tx), 32'(tx_ser));
    if (!locked) begin
      check("R9 sync low before comma", 32'(sync_flag), 32'd0);
    end else if (fire) begin
      check(cm ? "R3 comma group data" : "R1 group data", 32'(grp_data), 32'(hist));
      if (cm || !e_nxt_lag) begin
        check(cm ? "R6 comma on lead" : "R5 lead", {stb_lead, stb_lag}, 32'b10);
        e_nxt_lag = 1'b1;
      end else begin
        check("R5 lag", {stb_lead, stb_lag}, 32'b01);
        e_nxt_lag = 1'b0;
      end
      e_sync = cm;
      check(align_en ? "R7 sync at group" : "R4 sync ignored", 32'(sync_flag), 32'(e_sync));
    end else begin
      check("R5 idle strobes", {stb_lead, stb_lag}, 32'b00);
      check(align_en ? "R7 sync hold" : "R4 sync hold", 32'(sync_flag), 32'(e_sync));
    end
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int k = 0; k < 10; k++) step(w[k]);
  endtask

  task automatic zeros(input int n);
    for (int k = 0; k < n; k++) step(1'b0);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    hist = '0; since = 0; locked = 1'b0; e_nxt_lag = 1'b0; e_sync = 1'b0;
    line_rx = 1'b0; tx_ser = 1'b0; loop_sel = 1'b0; align_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset grp", 32'(grp_data), 32'd0);
    check("R9 reset strobes", {stb_lead, stb_lag}, 32'b00);
    check("R9 reset sync", 32'(sync_flag), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    zeros(25);

    // R3 alignment at every bit offset
    for (int off = 0; off < 10; off++) begin
      zeros(off);
      send_word(COMMA);
      for (int j = 0; j < 8; j++) send_word(word_of(off * 8 + j));
    end

    // R1 full sweep of the data words after an aligned comma
    send_word(COMMA);
    for (int j = 0; j < 256; j++) send_word(word_of(j));

    // R4 comma ignored while alignment is off
    align_en = 1'b0;
    zeros(3);
    send_word(COMMA);
    for (int j = 0; j < 12; j++) send_word(word_of(j + 37));
    zeros(7);
    send_word(COMMA);
    for (int j = 0; j < 5; j++) send_word(word_of(j + 90));

    // R8 loopback from the transmit stream
    align_en = 1'b1;
    loop_sel = 1'b1;
    zeros(5);
    send_word(COMMA);
    for (int j = 0; j < 20; j++) send_word(word_of(j * 11));
    loop_sel = 1'b0;
    zeros(4);
    send_word(COMMA);
    for (int j = 0; j < 6; j++) send_word(word_of(j * 13));

    // R9 reset in mid stream
    zeros(3);
    rst_n = 1'b0;
    #1;
    check("R9 async grp clear", 32'(grp_data), 32'd0);
    check("R9 async strobe clear", {stb_lead, stb_lag}, 32'b00);
    check("R9 async sync clear", 32'(sync_flag), 32'd0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    hist = '0; since = 0; locked = 1'b0; e_nxt_lag = 1'b0; e_sync = 1'b0;
    zeros(23);
    send_word(COMMA);
    for (int j = 0; j < 4; j++) send_word(word_of(j + 200));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule